// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital side of a serial port on an oversampling converter. A host talks to it over three pins: an active-low select, a serial clock that can run either way, and a data pin with an output enable. The block cycles through three states. In Converting, a result is being produced. In Sleep, a result is waiting. In Data Output, the result is shifted out. The conversion itself is a stub: it spends a fixed number of system clock cycles, then latches the sample on its input and turns it into a result word.

While the select is low and no word is being shifted, the data pin acts as a busy flag. It is high while converting and low once a result is ready, so the host can poll it. The clock direction is chosen by the level on the clock pad. That level is captured while reset is held, and again at every falling edge of the select. A high level, which is what the pad's weak pull-up gives when nobody drives it, selects the internal clock: the block then generates the bit clock itself. A low level selects the external clock: the host supplies the bit clock. Raising the select in the middle of a readout drops the rest of the word and starts a fresh conversion.

The select and the external clock are passed through a synchronizer into the system clock domain.

Top module: `adc_serial_port`

## Requirements
- R1: While the select has been high for more than SYNC_STAGES system cycles, `sdo_oe` is 0 (data pin floating).
- R2: With the select low, `sdo` is 1 while a conversion is in progress and 0 in Sleep.
- R3: When a conversion finishes, the block enters Sleep and stays there, with `sdo_oe` at 0, for as long as the select stays high.
- R4: A low select in Sleep starts Data Output and presents the most significant bit of the result on `sdo`.
- R5: The result is WORD_W bits, shifted out most significant bit first. `sdo` changes only after a falling edge of the bit clock and holds its value between such edges.
- R6: After the falling edge that ends the last bit, a new conversion starts on its own. With the select still low, `sdo` then reads 1.
- R7: A rising select during Data Output drops the rest of the word and starts a new conversion. The next readout returns the newly converted sample.
- R8: The clock mode comes from the clock pad level sampled during reset and at every falling select edge. A high level selects the internal clock; a low level selects the external clock. `sck_pullup` is 1 exactly in internal mode.
- R9: In internal mode `sck_oe` is 1 only during Data Output. `sck_out` starts low and toggles every SCK_DIV system cycles, giving WORD_W rising edges per complete word.
- R10: In external mode `sck_oe` stays 0, and the bit clock comes from `sck_in`.
- R11: The result word is built from the signed sample s.
  - If -HALF_FS <= s < HALF_FS, the word is {2'b01, s sign-extended to WORD_W-2 bits}.
  - If s >= HALF_FS, the word is the overrange code {2'b11, all zeros}.
  - If s < -HALF_FS, the word is the underrange code {2'b00, all ones}.
- R12: A conversion lasts CONV_CYC system cycles from entering Converting until Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the clock pad is sampled while it is low |
| cs_n | input | 1 | Active-low select from the host |
| sck_in | input | 1 | Level seen on the clock pad |
| sck_out | output | 1 | Bit clock driven in internal mode |
| sck_oe | output | 1 | Drive enable for the clock pad |
| sck_pullup | output | 1 | Weak pull-up enable for the clock pad |
| sdo | output | 1 | Serial data or busy flag |
| sdo_oe | output | 1 | Drive enable for the data pad |
| sample | input | SMP_W | Signed sample taken when a conversion ends |

## Verification
The bench builds the block with CONV_CYC=30, SCK_DIV=2 and SYNC_STAGES=2, keeping WORD_W=32, SMP_W=24 and HALF_FS=2^22. The short conversion lets dozens of full readouts run in both clock modes, along with aborts and busy polling. It also makes the conversion latency measurable against a narrow window of cycles. The small clock divider makes the internal bit-clock period directly checkable. A 24-bit sample with this full-scale limit lets random draws land on both sides of both range limits, so the in-range, overrange and underrange codes are all exercised.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
   typedef enum logic [1:0] {
      ST_CONV  = 2'd0,
      ST_SLEEP = 2'd1,
      ST_DOUT  = 2'd2
   } adc_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
   parameter int CONV_CYC = 200,
   parameter int SMP_W    = 24,
   parameter int WORD_W   = 32,
   parameter int HALF_FS  = 4194304
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic signed [SMP_W-1:0] sample,
   output logic                    done,
   output logic [WORD_W-1:0]       word
);
   localparam int CW  = $clog2(CONV_CYC + 1);
   localparam int EXT = WORD_W - 2 - SMP_W;

   logic [CW-1:0]      cnt;
   logic signed [31:0] sx;
   logic [WORD_W-1:0]  coded;

   assign done = run && (cnt == CW'(CONV_CYC - 1));

   // range classification of the latched sample
   always_comb begin
      sx = {{(32 - SMP_W){sample[SMP_W-1]}}, sample};
      if (sx >= HALF_FS)
         coded = {2'b11, {(WORD_W-2){1'b0}}};
      else if (sx < -HALF_FS)
         coded = {2'b00, {(WORD_W-2){1'b1}}};
      else
         coded = {2'b01, {EXT{sample[SMP_W-1]}}, sample};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         word <= '0;
      end else begin
         if (!run)      cnt <= '0;
         else if (!done) cnt <= cnt + 1'b1;
         if (done) word <= coded;
      end
   end
endmodule

// File: rtl/adc_shifter.sv
module adc_shifter #(
   parameter int WORD_W  = 32,
   parameter int SCK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              active,
   input  logic              int_mode,
   input  logic              ext_fall,
   input  logic [WORD_W-1:0] word,
   output logic              sdo_bit,
   output logic              shift_evt,
   output logic              last,
   output logic              sck_out
);
   localparam int BW = $clog2(WORD_W);

   logic              run_int;
   logic              tick;
   logic [WORD_W-1:0] sreg;
   logic [BW-1:0]     bcnt;

   assign run_int = active && int_mode;

   if (SCK_DIV == 1) begin : g_div_one
      assign tick = 1'b1;
   end else begin : g_div_cnt
      localparam int DW = $clog2(SCK_DIV);
      logic [DW-1:0] div;
      assign tick = (div == DW'(SCK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        div <= '0;
         else if (!run_int) div <= '0;
         else if (tick)     div <= '0;
         else               div <= div + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sck_out <= 1'b0;
      else if (!run_int) sck_out <= 1'b0;
      else if (tick)     sck_out <= ~sck_out;
   end

   assign shift_evt = active && (int_mode ? (tick && sck_out) : ext_fall);
   assign last      = shift_evt && (bcnt == BW'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         bcnt <= '0;
      end else if (load) begin
         sreg <= word;
         bcnt <= '0;
      end else if (shift_evt) begin
         sreg <= {sreg[WORD_W-2:0], 1'b0};
         bcnt <= bcnt + 1'b1;
      end
   end

   assign sdo_bit = sreg[WORD_W-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_port_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int SMP_W       = 24,
   parameter int HALF_FS     = 4194304,
   parameter int CONV_CYC    = 200,
   parameter int SCK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    sck_in,
   output logic                    sck_out,
   output logic                    sck_oe,
   output logic                    sck_pullup,
   output logic                    sdo,
   output logic                    sdo_oe,
   input  logic signed [SMP_W-1:0] sample
);
   if (WORD_W < SMP_W + 3) begin : g_bad_word
      $error("adc_serial_port: WORD_W too small for SMP_W");
   end
   if (SMP_W > 31 || HALF_FS < 1 || HALF_FS > (1 << (SMP_W - 1))) begin : g_bad_fs
      $error("adc_serial_port: HALF_FS out of range for SMP_W");
   end
   if (CONV_CYC < 2) begin : g_bad_conv
      $error("adc_serial_port: CONV_CYC must be at least 2");
   end
   if (SCK_DIV < 1) begin : g_bad_div
      $error("adc_serial_port: SCK_DIV must be at least 1");
   end

   adc_state_e        st, st_nx;
   logic              cs_s, cs_d, sck_s, sck_d;
   logic              cs_rise, cs_fall, sck_fall;
   logic              int_mode;
   logic              conv_done, load;
   logic              sdo_bit, shift_evt, last;
   logic [WORD_W-1:0] word;

   adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign cs_rise  = cs_s & ~cs_d;
   assign cs_fall  = ~cs_s & cs_d;
   assign sck_fall = ~sck_s & sck_d;

   // clock direction: pad level during reset, then at every select fall
   always_ff @(posedge clk) begin
      if (!rst_n)       int_mode <= sck_in;
      else if (cs_fall) int_mode <= sck_s;
   end

   assign load = (st == ST_SLEEP) && !cs_s;

   always_comb begin
      st_nx = st;
      case (st)
         ST_CONV:  if (conv_done) st_nx = ST_SLEEP;
         ST_SLEEP: if (!cs_s)     st_nx = ST_DOUT;
         ST_DOUT:  if (cs_rise || last) st_nx = ST_CONV;
         default:  st_nx = ST_CONV;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_CONV;
      else        st <= st_nx;
   end

   adc_conv_stub #(
      .CONV_CYC(CONV_CYC), .SMP_W(SMP_W), .WORD_W(WORD_W), .HALF_FS(HALF_FS)
   ) i_conv (
      .clk(clk), .rst_n(rst_n), .run(st == ST_CONV), .sample(sample),
      .done(conv_done), .word(word));

   adc_shifter #(.WORD_W(WORD_W), .SCK_DIV(SCK_DIV)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .active(st == ST_DOUT),
      .int_mode(int_mode), .ext_fall(sck_fall), .word(word),
      .sdo_bit(sdo_bit), .shift_evt(shift_evt), .last(last), .sck_out(sck_out));

   assign sdo        = (st == ST_DOUT) ? sdo_bit : (st == ST_CONV);
   assign sdo_oe     = ~cs_s;
   assign sck_oe     = int_mode && (st == ST_DOUT);
   assign sck_pullup = int_mode;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
   import adc_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sdo,
   input logic       sdo_oe,
   input logic       sck_oe,
   input logic       sck_pullup,
   input adc_state_e st,
   input logic       conv_done,
   input logic       shift_evt,
   input logic       cs_rise
);
   localparam int CW = $clog2(SYNC_STAGES + 2) + 1;

   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hi_cnt <= '0;
      else if (!cs_n)                            hi_cnt <= '0;
      else if (hi_cnt != CW'(SYNC_STAGES + 1))   hi_cnt <= hi_cnt + 1'b1;
   end

   a_r1_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > CW'(SYNC_STAGES)) |-> !sdo_oe);

   a_r2_busy_flag_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && st == ST_CONV) |-> sdo);

   a_r2_ready_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && st == ST_SLEEP) |-> !sdo);

   a_r3_sleep_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONV && conv_done) |=> (st == ST_SLEEP));

   a_r3_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP && hi_cnt > CW'(SYNC_STAGES)) |=> (st == ST_SLEEP));

   a_r5_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOUT && !shift_evt && !cs_rise) |=> (st == ST_DOUT && $stable(sdo)));

   a_r7_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOUT && cs_rise) |=> (st == ST_CONV));

   a_r9_drive_only_in_output: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_DOUT) |-> !sck_oe);

   a_r8_pullup_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> sck_pullup);
endmodule

bind adc_serial_port adc_serial_port_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
   .sck_oe(sck_oe), .sck_pullup(sck_pullup), .st(st), .conv_done(conv_done),
   .shift_evt(shift_evt), .cs_rise(cs_rise));

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;
   localparam int WORD_W   = 32;
   localparam int SMP_W    = 24;
   localparam int HALF_FS  = 4194304;
   localparam int CONV_CYC = 30;
   localparam int SCK_DIV  = 2;
   localparam int SYNC     = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic host_en = 1'b1;
   logic host_sck = 1'b0;
   logic sck_pad, sck_out, sck_oe, sck_pullup, sdo, sdo_oe;
   logic signed [SMP_W-1:0] sample = '0;
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign sck_pad = sck_oe ? sck_out : (host_en ? host_sck : 1'b1);

   adc_serial_port #(
      .WORD_W(WORD_W), .SMP_W(SMP_W), .HALF_FS(HALF_FS),
      .CONV_CYC(CONV_CYC), .SCK_DIV(SCK_DIV), .SYNC_STAGES(SYNC)
   ) i_adc_serial_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_pad),
      .sck_out(sck_out), .sck_oe(sck_oe), .sck_pullup(sck_pullup),
      .sdo(sdo), .sdo_oe(sdo_oe), .sample(sample));

   function automatic logic [31:0] enc(input int s);
      if (s >= HALF_FS)  return 32'hC000_0000;
      if (s < -HALF_FS)  return 32'h3FFF_FFFF;
      return {2'b01, 30'(s)};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_ext(input int nbits, output logic [31:0] w);
      w = '0;
      for (int i = 0; i < nbits; i++) begin
         w = {w[30:0], sdo};
         host_sck = 1'b1; tick(3);
         host_sck = 1'b0; tick(4);
      end
   endtask

   task automatic read_int(output logic [31:0] w, output int period);
      int t0;
      w = '0; t0 = 0; period = 0;
      for (int i = 0; i < WORD_W; i++) begin
         @(posedge sck_out);
         if (i == 1) t0 = cyc;
         if (i == 2) period = cyc - t0;
         @(negedge clk);
         w = {w[30:0], sdo};
      end
   endtask

   task automatic set_ext();
      host_en = 1'b1; host_sck = 1'b0; tick(3);
   endtask

   task automatic set_int();
      host_en = 1'b0; tick(3);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] w;
      int n, per, s;
      void'($urandom(32'h5EED_0C0D));
      sample = 24'sd123;
      tick(5);
      // R8: pad held low through reset -> external mode
      chk(sdo_oe == 1'b0, "R1 reset floating", 32'(sdo_oe), 0);
      chk(sck_pullup == 1'b0, "R8 external at reset", 32'(sck_pullup), 0);
      rst_n = 1'b1;
      tick(2);
      cs_n = 1'b0; tick(4);
      chk(sdo_oe && sdo, "R2 busy flag while converting", {sdo_oe, sdo}, 32'h3);
      chk(sck_oe == 1'b0, "R10 no drive in external mode", 32'(sck_oe), 0);
      cs_n = 1'b1; tick(CONV_CYC + 10);
      chk(sdo_oe == 1'b0, "R3 sleep floating", 32'(sdo_oe), 0);

      // R4 R5: first external readout
      cs_n = 1'b0; tick(5);
      read_ext(32, w);
      chk(w == enc(123), "R4 R5 word MSB first", w, enc(123));
      sample = -24'sd5;
      tick(2);
      chk(sdo == 1'b1, "R6 auto restart busy", 32'(sdo), 1);
      // R12 R2: poll the flag until ready
      n = 6;
      while (sdo && n < 300) begin tick(1); n++; end
      chk(n >= CONV_CYC && n <= CONV_CYC + 8, "R12 latency window", n, CONV_CYC);
      tick(3);
      read_ext(32, w);
      chk(w == enc(-5), "R11 negative in range", w, enc(-5));
      cs_n = 1'b1; tick(4);
      chk(sdo_oe == 1'b0, "R1 floating after read", 32'(sdo_oe), 0);

      // R11 range codes
      sample = 24'(HALF_FS);
      tick(CONV_CYC + 10); cs_n = 1'b0; tick(5);
      read_ext(32, w); cs_n = 1'b1;
      chk(w == 32'hC000_0000, "R11 overrange code", w, 32'hC000_0000);
      sample = 24'(-HALF_FS - 1);
      tick(CONV_CYC + 10); cs_n = 1'b0; tick(5);
      read_ext(32, w); cs_n = 1'b1;
      chk(w == 32'h3FFF_FFFF, "R11 underrange code", w, 32'h3FFF_FFFF);

      // R7 abort mid-word
      sample = 24'sd1000;
      tick(CONV_CYC + 10); cs_n = 1'b0; tick(5);
      read_ext(8, w);
      chk(w[7:0] == enc(1000) >> 24, "R7 partial bits", w[7:0], enc(1000) >> 24);
      cs_n = 1'b1; sample = 24'sd2000; tick(4);
      chk(sdo_oe == 1'b0, "R1 floating after abort", 32'(sdo_oe), 0);
      cs_n = 1'b0; tick(4);
      chk(sdo == 1'b1, "R7 new conversion after abort", 32'(sdo), 1);
      cs_n = 1'b1; tick(CONV_CYC + 10);
      cs_n = 1'b0; tick(5);
      read_ext(32, w); cs_n = 1'b1;
      chk(w == enc(2000), "R7 fresh sample after abort", w, enc(2000));

      // R8 R9 internal mode
      sample = 24'sd77;
      tick(CONV_CYC + 10);
      set_int();
      cs_n = 1'b0; tick(1);
      read_int(w, per);
      chk(w == enc(77), "R9 internal readout", w, enc(77));
      chk(per == 2 * SCK_DIV, "R9 bit clock period", per, 2 * SCK_DIV);
      tick(3);
      chk(sck_pullup == 1'b1, "R8 internal mode latched", 32'(sck_pullup), 1);
      chk(sck_oe == 1'b0 && sdo == 1'b1, "R9 R6 release after word", {sck_oe, sdo}, 32'h1);
      cs_n = 1'b1; tick(4);
      set_ext();
      cs_n = 1'b0; tick(5);
      chk(sck_pullup == 1'b0, "R8 back to external", 32'(sck_pullup), 0);
      cs_n = 1'b1; tick(4);

      // random mix of samples and modes
      for (int k = 0; k < 40; k++) begin
         bit im;
         s = int'($urandom_range(0, 2 * (HALF_FS + HALF_FS / 4))) - (HALF_FS + HALF_FS / 4);
         if (k == 0) s = HALF_FS - 1;
         if (k == 1) s = -HALF_FS;
         im = 1'($urandom_range(0, 1));
         sample = 24'(s);
         tick(CONV_CYC + 10);
         if (im) set_int(); else set_ext();
         cs_n = 1'b0;
         if (im) begin
            tick(1); read_int(w, per);
         end else begin
            tick(5); read_ext(32, w);
         end
         cs_n = 1'b1;
         chk(w == enc(s), im ? "R9 R11 random internal" : "R10 R11 random external", w, enc(s));
         tick(3);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule